// File: doc/BRIEF.md
# Event Definition Pattern Matcher

Once per machine pulse (a 360 Hz rate in use) the block receives a beam pattern made of a beam code and a vector of pattern bits. The pattern bits hold the legacy pattern bits in the low 16 positions and the local modifier bits in the high 8. The block compares the pattern with a bank of twenty stored event definitions. It returns a twenty-bit event vector in which bit *i* reports whether definition *i* matched. That vector is appended to the outgoing broadcast, where receivers use it to gate beam-synchronous acquisition.

Each definition holds a beam code, a mask of bits that must be set and a mask of bits that must be clear. The five lowest slots belong to the system (one hertz, ten hertz, full rate, single shot, feedback) and always take part in matching. The fifteen upper slots are lent to clients. A client asks for a slot and is given the lowest free one. It fills in the definition and then arms the slot with a go command. Only armed client slots produce event bits. A single command port carries definition writes, reservations, go, stop and release.

Top module: `edef_matcher`

## Requirements
- R1: Every cycle with `pat_valid` high is answered exactly one cycle later by a single-cycle `evt_valid` pulse. `evt_bits` is all zero whenever `evt_valid` is low.
- R2: There are 20 slots, and bit *i* of `evt_bits` belongs to slot *i*, with slot 0 in the least significant bit.
- R3: An enabled slot sets its bit only when three conditions all hold: `pat_code` equals its stored code, every bit of its inclusion mask is set in `pat_bits`, and no bit of its exclusion mask is set in `pat_bits`. Both masks use the same bit positions as `pat_bits`.
- R4: Slots 0 to 4 are system slots and always take part in matching. Set-go, clear-go and release commands addressed to them have no effect.
- R5: Slots 5 to 19 are client slots. Each is free, held or armed, and only an armed slot can set its event bit.
- R6: A reserve command answers on the next cycle with `rsv_done` high, `rsv_busy` low and `rsv_slot` equal to the lowest-numbered free client slot. That slot becomes held.
- R7: When no client slot is free, a reserve command answers with `rsv_done` high, `rsv_busy` high and `rsv_slot` zero, and no slot changes state. Outside reserve answers, all three `rsv_*` outputs are zero.
- R8: Clear-go returns an armed slot to held, so its bit reads zero from the next pulse on. Release returns a client slot to free and zeroes its code and both masks.
- R9: Definition writes to a free client slot are ignored. Set-go on a free client slot is ignored. Any command whose slot number is 20 or above is ignored.
- R10: A command presented in the same cycle as `pat_valid` does not affect that pulse's result. It first applies to the next pulse.
- R11: After reset every code and mask is zero, every client slot is free, and all outputs are zero.
- R12: The `cfg_op` codes are: 0 write code (from `cfg_data[4:0]`), 1 write inclusion mask, 2 write exclusion mask, 3 reserve, 4 set go, 5 clear go, 6 release, 7 no operation. A command is accepted only when `cfg_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_valid | input | 1 | Pattern strobe, one cycle per pulse |
| pat_code | input | 5 | Beam code of the pulse |
| pat_bits | input | 24 | Legacy bits [15:0] and modifier bits [23:16] |
| cfg_valid | input | 1 | Command strobe |
| cfg_op | input | 3 | Command code |
| cfg_slot | input | 5 | Target slot for the command |
| cfg_data | input | 24 | Code or mask value to write |
| rsv_done | output | 1 | Reservation answer strobe |
| rsv_busy | output | 1 | No free client slot was available |
| rsv_slot | output | 5 | Slot granted by the reservation |
| evt_valid | output | 1 | Event vector valid pulse |
| evt_bits | output | 20 | Per-slot match result |

## Verification
The hardest states to reach from the ports are a fully reserved client bank that has then been released out of order, and a command that lands in the same cycle as a pulse. Reaching the first requires reserving every client slot until the busy answer appears, then releasing slots from the middle of the bank, so that the next grants must fill those holes in ascending order. The stimulus runs exactly that sequence. It then issues clear-go and release commands in the same cycle as a pattern strobe, and finishes with a long stretch of random pulses and commands that include slot numbers beyond the bank. A behavioural model checks every one of these cases on every clock.

// File: rtl/edef_pkg.sv
package edef_pkg;

  typedef enum logic [2:0] {
    OP_WR_CODE = 3'd0,
    OP_WR_INCL = 3'd1,
    OP_WR_EXCL = 3'd2,
    OP_RESERVE = 3'd3,
    OP_SET_GO  = 3'd4,
    OP_CLR_GO  = 3'd5,
    OP_RELEASE = 3'd6,
    OP_NOP     = 3'd7
  } cfg_op_e;

  typedef enum logic [1:0] {
    SL_FREE  = 2'd0,
    SL_HELD  = 2'd1,
    SL_ARMED = 2'd2
  } slot_st_e;

endpackage

// File: rtl/edef_alloc.sv
module edef_alloc #(
  parameter int N_SLOTS = 20,
  parameter int N_SYS   = 5,
  parameter int SLOT_W  = 5
) (
  input  logic [N_SLOTS-1:0] free_vec,
  output logic               found,
  output logic [SLOT_W-1:0]  idx
);

  // lowest free client slot: scan downward so the last hit wins
  function automatic logic [SLOT_W:0] lowest_free(input logic [N_SLOTS-1:0] fv);
    logic [SLOT_W:0] r;
    r = '0;
    for (int k = N_SLOTS - 1; k >= N_SYS; k--) begin
      if (fv[k]) r = {1'b1, SLOT_W'(k)};
    end
    return r;
  endfunction

  logic [SLOT_W:0] pick;
  assign pick  = lowest_free(free_vec);
  assign found = pick[SLOT_W];
  assign idx   = pick[SLOT_W-1:0];

endmodule

// File: rtl/edef_slot_bank.sv
module edef_slot_bank
  import edef_pkg::*;
#(
  parameter int N_SLOTS = 20,
  parameter int N_SYS   = 5,
  parameter int CODE_W  = 5,
  parameter int MASK_W  = 24,
  parameter int SLOT_W  = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_valid,
  input  logic [2:0]                      cfg_op,
  input  logic [SLOT_W-1:0]               cfg_slot,
  input  logic [MASK_W-1:0]               cfg_data,
  output logic [N_SLOTS-1:0][CODE_W-1:0]  code_q,
  output logic [N_SLOTS-1:0][MASK_W-1:0]  incl_q,
  output logic [N_SLOTS-1:0][MASK_W-1:0]  excl_q,
  output logic [N_SLOTS-1:0]              armed_vec,
  output logic                            rsv_done,
  output logic                            rsv_busy,
  output logic [SLOT_W-1:0]               rsv_slot
);

  localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(N_SLOTS);
  localparam logic [SLOT_W-1:0] SYS_LIM  = SLOT_W'(N_SYS);

  cfg_op_e            op;
  logic [N_SLOTS-1:0] free_vec;
  logic               alloc_found;
  logic [SLOT_W-1:0]  alloc_idx;
  logic               rsv_req;

  assign op      = cfg_op_e'(cfg_op);
  assign rsv_req = cfg_valid && (op == OP_RESERVE);

  edef_alloc #(.N_SLOTS(N_SLOTS), .N_SYS(N_SYS), .SLOT_W(SLOT_W)) u_alloc (
    .free_vec (free_vec),
    .found    (alloc_found),
    .idx      (alloc_idx)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic              sel;
    logic [CODE_W-1:0] code_r;
    logic [MASK_W-1:0] incl_r;
    logic [MASK_W-1:0] excl_r;
    assign sel = cfg_valid && (cfg_slot == SLOT_W'(i));

    if (i < N_SYS) begin : g_sys
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_r <= '0;
          incl_r <= '0;
          excl_r <= '0;
        end else if (sel) begin
          case (op)
            OP_WR_CODE: code_r <= cfg_data[CODE_W-1:0];
            OP_WR_INCL: incl_r <= cfg_data;
            OP_WR_EXCL: excl_r <= cfg_data;
            default: ;
          endcase
        end
      end
      assign armed_vec[i] = 1'b1;
      assign free_vec[i]  = 1'b0;
    end else begin : g_client
      slot_st_e st;
      logic     take;
      assign take = rsv_req && alloc_found && (alloc_idx == SLOT_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st     <= SL_FREE;
          code_r <= '0;
          incl_r <= '0;
          excl_r <= '0;
        end else if (take) begin
          st <= SL_HELD;
        end else if (sel) begin
          case (op)
            OP_WR_CODE: if (st != SL_FREE) code_r <= cfg_data[CODE_W-1:0];
            OP_WR_INCL: if (st != SL_FREE) incl_r <= cfg_data;
            OP_WR_EXCL: if (st != SL_FREE) excl_r <= cfg_data;
            OP_SET_GO:  if (st == SL_HELD) st <= SL_ARMED;
            OP_CLR_GO:  if (st == SL_ARMED) st <= SL_HELD;
            OP_RELEASE: begin
              st     <= SL_FREE;
              code_r <= '0;
              incl_r <= '0;
              excl_r <= '0;
            end
            default: ;
          endcase
        end
      end
      assign armed_vec[i] = (st == SL_ARMED);
      assign free_vec[i]  = (st == SL_FREE);
    end

    assign code_q[i] = code_r;
    assign incl_q[i] = incl_r;
    assign excl_q[i] = excl_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_done <= 1'b0;
      rsv_busy <= 1'b0;
      rsv_slot <= '0;
    end else begin
      rsv_done <= rsv_req;
      rsv_busy <= rsv_req && !alloc_found;
      rsv_slot <= (rsv_req && alloc_found) ? alloc_idx : '0;
    end
  end

  // R6
  rsv_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_req |=> rsv_done);

  // R6
  rsv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_done && !rsv_busy) |-> (rsv_slot >= SYS_LIM && rsv_slot < SLOT_LIM));

  // R7
  rsv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_busy |-> (rsv_done && rsv_slot == '0));

  // R8
  release_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && op == OP_RELEASE && cfg_slot >= SYS_LIM && cfg_slot < SLOT_LIM)
      |=> !armed_vec[$past(cfg_slot)]);

  // R4
  sys_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && op == OP_RELEASE && cfg_slot < SYS_LIM)
      |=> armed_vec[$past(cfg_slot)]);

endmodule

// File: rtl/edef_match_array.sv
module edef_match_array #(
  parameter int N_SLOTS = 20,
  parameter int CODE_W  = 5,
  parameter int MASK_W  = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pat_valid,
  input  logic [CODE_W-1:0]               pat_code,
  input  logic [MASK_W-1:0]               pat_bits,
  input  logic [N_SLOTS-1:0][CODE_W-1:0]  code_q,
  input  logic [N_SLOTS-1:0][MASK_W-1:0]  incl_q,
  input  logic [N_SLOTS-1:0][MASK_W-1:0]  excl_q,
  input  logic [N_SLOTS-1:0]              armed_vec,
  output logic                            evt_valid,
  output logic [N_SLOTS-1:0]              evt_bits
);

  function automatic logic slot_hit(
    input logic [CODE_W-1:0] pc,
    input logic [MASK_W-1:0] pb,
    input logic [CODE_W-1:0] dc,
    input logic [MASK_W-1:0] need_set,
    input logic [MASK_W-1:0] need_clr
  );
    return (pc == dc) && ((pb & need_set) == need_set) && ((pb & need_clr) == '0);
  endfunction

  logic [N_SLOTS-1:0] hit_vec;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_cmp
    assign hit_vec[i] = armed_vec[i] &&
                        slot_hit(pat_code, pat_bits, code_q[i], incl_q[i], excl_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_bits  <= '0;
    end else begin
      evt_valid <= pat_valid;
      evt_bits  <= pat_valid ? hit_vec : '0;
    end
  end

  // R1
  evt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |=> evt_valid);

  // R1
  evt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> (evt_bits == '0));

  // R5
  evt_armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ((evt_bits & ~$past(armed_vec)) == '0));

endmodule

// File: rtl/edef_matcher.sv
module edef_matcher #(
  parameter int N_SLOTS = 20,
  parameter int N_SYS   = 5,
  parameter int CODE_W  = 5,
  parameter int LEG_W   = 16,
  parameter int MOD_W   = 8,
  localparam int MASK_W = LEG_W + MOD_W,
  localparam int SLOT_W = $clog2(N_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pat_valid,
  input  logic [CODE_W-1:0]  pat_code,
  input  logic [MASK_W-1:0]  pat_bits,
  input  logic               cfg_valid,
  input  logic [2:0]         cfg_op,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [MASK_W-1:0]  cfg_data,
  output logic               rsv_done,
  output logic               rsv_busy,
  output logic [SLOT_W-1:0]  rsv_slot,
  output logic               evt_valid,
  output logic [N_SLOTS-1:0] evt_bits
);

  logic [N_SLOTS-1:0][CODE_W-1:0] code_q;
  logic [N_SLOTS-1:0][MASK_W-1:0] incl_q;
  logic [N_SLOTS-1:0][MASK_W-1:0] excl_q;
  logic [N_SLOTS-1:0]             armed_vec;

  edef_slot_bank #(
    .N_SLOTS(N_SLOTS), .N_SYS(N_SYS), .CODE_W(CODE_W),
    .MASK_W(MASK_W), .SLOT_W(SLOT_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_op    (cfg_op),
    .cfg_slot  (cfg_slot),
    .cfg_data  (cfg_data),
    .code_q    (code_q),
    .incl_q    (incl_q),
    .excl_q    (excl_q),
    .armed_vec (armed_vec),
    .rsv_done  (rsv_done),
    .rsv_busy  (rsv_busy),
    .rsv_slot  (rsv_slot)
  );

  edef_match_array #(
    .N_SLOTS(N_SLOTS), .CODE_W(CODE_W), .MASK_W(MASK_W)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .pat_valid (pat_valid),
    .pat_code  (pat_code),
    .pat_bits  (pat_bits),
    .code_q    (code_q),
    .incl_q    (incl_q),
    .excl_q    (excl_q),
    .armed_vec (armed_vec),
    .evt_valid (evt_valid),
    .evt_bits  (evt_bits)
  );

  // R1
  evt_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !$past(pat_valid)) |-> 1'b0);

endmodule

// File: tb/edef_matcher_tb.sv
module edef_matcher_tb;

  localparam int N = 20;
  localparam int NS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pat_valid = 1'b0;
  logic [4:0]  pat_code = '0;
  logic [23:0] pat_bits = '0;
  logic        cfg_valid = 1'b0;
  logic [2:0]  cfg_op = 3'd7;
  logic [4:0]  cfg_slot = '0;
  logic [23:0] cfg_data = '0;
  logic        rsv_done, rsv_busy;
  logic [4:0]  rsv_slot;
  logic        evt_valid;
  logic [19:0] evt_bits;

  always #2 clk = ~clk;

  edef_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_code(pat_code),
    .pat_bits(pat_bits), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
    .cfg_slot(cfg_slot), .cfg_data(cfg_data), .rsv_done(rsv_done),
    .rsv_busy(rsv_busy), .rsv_slot(rsv_slot), .evt_valid(evt_valid),
    .evt_bits(evt_bits)
  );

  // behavioural reference: 0 free, 1 held, 2 armed
  int          m_code [N];
  int          m_incl [N];
  int          m_excl [N];
  int          m_st   [N];
  bit          e_valid = 0, e_done = 0, e_busy = 0;
  int          e_bits = 0, e_slot = 0;
  int          n_cmp = 0, n_bad = 0;
  bit          finished = 0;

  initial for (int k = 0; k < N; k++) begin
    m_code[k] = 0; m_incl[k] = 0; m_excl[k] = 0; m_st[k] = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        m_code[k] = 0; m_incl[k] = 0; m_excl[k] = 0; m_st[k] = 0;
      end
      e_valid = 0; e_bits = 0; e_done = 0; e_busy = 0; e_slot = 0;
    end else begin
      // match uses the state before this edge (R10)
      e_valid = pat_valid;
      e_bits = 0;
      if (pat_valid)
        for (int k = 0; k < N; k++) begin
          bit on;
          on = (k < NS) || (m_st[k] == 2);
          if (on && int'(pat_code) == m_code[k]
              && ((int'(pat_bits) & m_incl[k]) == m_incl[k])
              && ((int'(pat_bits) & m_excl[k]) == 0))
            e_bits = e_bits | (1 << k);
        end
      e_done = 0; e_busy = 0; e_slot = 0;
      if (cfg_valid) begin
        int s;
        s = int'(cfg_slot);
        if (cfg_op == 3) begin
          int got;
          got = -1;
          for (int k = N - 1; k >= NS; k--) if (m_st[k] == 0) got = k;
          e_done = 1;
          if (got < 0) e_busy = 1;
          else begin e_slot = got; m_st[got] = 1; end
        end else if (s < N) begin
          bit wr_ok;
          wr_ok = (s < NS) || (m_st[s] != 0);
          case (cfg_op)
            3'd0: if (wr_ok) m_code[s] = int'(cfg_data) & 31;
            3'd1: if (wr_ok) m_incl[s] = int'(cfg_data);
            3'd2: if (wr_ok) m_excl[s] = int'(cfg_data);
            3'd4: if (s >= NS && m_st[s] == 1) m_st[s] = 2;
            3'd5: if (s >= NS && m_st[s] == 2) m_st[s] = 1;
            3'd6: if (s >= NS) begin
              m_st[s] = 0; m_code[s] = 0; m_incl[s] = 0; m_excl[s] = 0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        check(evt_valid == 1'b0 && evt_bits == '0, "R11 evt", int'(evt_bits), 0);
        check(rsv_done == 1'b0 && rsv_busy == 1'b0 && rsv_slot == '0, "R11 rsv",
              int'(rsv_slot), 0);
      end else begin
        check(evt_valid == e_valid, "R1 evt_valid", int'(evt_valid), int'(e_valid));
        check(int'(evt_bits) == e_bits, "R2 R3 R4 R5 R8 R9 R10 evt_bits",
              int'(evt_bits), e_bits);
        check(rsv_done == e_done, "R6 R12 rsv_done", int'(rsv_done), int'(e_done));
        check(rsv_busy == e_busy, "R7 rsv_busy", int'(rsv_busy), int'(e_busy));
        check(int'(rsv_slot) == e_slot, "R6 R7 rsv_slot", int'(rsv_slot), e_slot);
      end
    end
  end

  task automatic step(input bit pv, input int pc, input int pb,
                      input bit cv, input int op, input int sl, input int d);
    @(negedge clk);
    pat_valid = pv; pat_code = 5'(pc); pat_bits = 24'(pb);
    cfg_valid = cv; cfg_op = 3'(op); cfg_slot = 5'(sl); cfg_data = 24'(d);
  endtask

  task automatic cmd(input int op, input int sl, input int d);
    step(0, 0, 0, 1, op, sl, d);
  endtask

  task automatic pulse(input int pc, input int pb);
    step(1, pc, pb, 0, 7, 0, 0);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 7, 0, 0);
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();
    // R11: reset definitions are zero, so system slots hit code 0 with any bits
    pulse(0, 24'h123456);
    // R3: system slot 0 required-set / required-clear / code
    cmd(0, 0, 3); cmd(1, 0, 24'h000005); cmd(2, 0, 24'h010000);
    pulse(3, 24'h5); pulse(3, 24'h7); pulse(3, 24'h10005);
    pulse(3, 24'h4); pulse(2, 24'h5);
    cmd(0, 4, 3);
    pulse(3, 24'h0);
    // R9: free client slot ignores writes and go
    cmd(0, 7, 3); cmd(4, 7, 0); pulse(3, 0); pulse(0, 0);
    // R6 R7: fill the bank, then busy
    for (int k = 0; k < 16; k++) cmd(3, 0, 0);
    idle();
    for (int k = NS; k < N; k++) begin
      cmd(0, k, 3); cmd(1, k, 1 << (k - NS));
      if (k % 2 == 1) cmd(4, k, 0);
    end
    pulse(3, 24'h7FFF); pulse(3, 24'h00AA); pulse(1, 24'h7FFF);
    // R4: go/release on system slot ignored
    cmd(6, 2, 0); cmd(5, 0, 0); pulse(3, 24'h5);
    // R10 R8: clear go together with pulse
    step(1, 3, 24'h7FFF, 1, 5, 9, 0);
    pulse(3, 24'h7FFF);
    step(1, 3, 24'h7FFF, 1, 6, 11, 0);
    pulse(3, 24'h7FFF);
    // R6: holes fill lowest first
    cmd(6, 12, 0); cmd(6, 6, 0);
    cmd(3, 0, 0); cmd(3, 0, 0); cmd(3, 0, 0); cmd(3, 0, 0);
    idle();
    // R9: out-of-range slot ignored
    cmd(6, 21, 0); cmd(0, 25, 3); pulse(3, 24'h7FFF);
    // random stretch
    for (int k = 0; k < 3000; k++) begin
      int pc, sl;
      pc = ($urandom % 4 == 0) ? int'($urandom % 32) : 3;
      sl = int'($urandom % 24);
      step(bit'($urandom % 2), pc, int'($urandom & 24'hFFFFFF),
           bit'($urandom % 2), int'($urandom % 8), sl, int'($urandom & 24'h0000FF));
    end
    idle(); idle();
    summary();
  end

endmodule